// File: doc/BRIEF.md
# Encoded Field Register Access Unit

This unit holds a bank of control-structure fields that software reaches through a 32-bit field encoding instead of a flat address. Each request carries an encoding operand, a direction (read or write), 64 bits of write data and a flag saying whether the requester runs in 64-bit mode. The unit splits the encoding into a width class, a type class, an index and an access-type bit. It rejects malformed encodings. For accepted requests it reads or writes the selected field, truncating, zero-extending or selecting the upper half as the width class and the mode require.

Each combination of width class, type class and index in range has its own 64-bit storage slot. The number of indices per width/type pair is a parameter. Writes land on the next clock edge. Read data and the fail flag come back registered, one cycle after the request.

Top module: `encfield_access_unit`

## Requirements
- R1: Reset clears every field to zero and drives the read data and the fail flag low. A read issued after reset returns zero.
- R2: The encoding layout is width class in bits 14:13, type class in bits 11:10, index in bits 9:1 and access type in bit 0. A request that sets any of bits 31:15, or bit 12, fails.
- R3: With the mode flag high, a request whose operand has any of bits 63:32 set fails. With the mode flag low, those operand bits are ignored.
- R4: Access-type bit 0 may be 1 only for width class 1 (full 64-bit). With any other width class, bit 0 = 1 fails.
- R5: An index at or above the configured count per width/type pair fails.
- R6: A failed request changes no field, returns zero read data, and raises the fail flag for exactly the one response cycle.
- R7: Width class 0 (16-bit): a read returns field bits 15:0 with result bits 63:16 zero. A write stores only source bits 15:0.
- R8: Width class 2 (32-bit): a read returns field bits 31:0 with result bits 63:32 zero. A write stores only source bits 31:0.
- R9: Width classes 1 and 3 with bit 0 = 0 and the mode flag low: a read returns field bits 31:0 only. A write stores source bits 31:0 and clears field bits 63:32.
- R10: Width classes 1 and 3 with bit 0 = 0 and the mode flag high: a read or write moves all 64 bits.
- R11: Width class 1 with bit 0 = 1 (upper half): a read returns field bits 63:32 in result bits 31:0, with the upper result bits zero. A write puts source bits 31:0 into field bits 63:32 and leaves field bits 31:0 unchanged.
- R12: The response appears one cycle after the request. A read issued in the cycle after a write to the same field returns the new value. Responses to writes and idle cycles carry zero read data.
- R13: Fields that differ only in type class or index are separate storage. Writing one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqEncoding | input | 64 | Field encoding operand |
| reqWdata | input | 64 | Write source data |
| mode64 | input | 1 | Requester is in 64-bit mode |
| rspRdata | output | 64 | Registered, shaped read result |
| rspFail | output | 1 | Registered failure flag for the previous request |

## Verification
The assertions assume that the request inputs are settled and free of X at each rising clock edge. They also assume reqValid is low while reset is held, because the failure and storage-stability properties look back one cycle at the decoded request. The bench meets both assumptions:
- It changes inputs only on falling edges.
- It keeps reqValid low through each reset pulse.

Its encodings deliberately cover reserved bits, upper operand bits, a stray access-type bit and an out-of-range index, each in its own request, so that every failure cause is seen on its own.

// File: rtl/encfield_pkg.sv
`timescale 1ns/1ps
package encfield_pkg;

  typedef enum logic [1:0] {
    WID_16     = 2'd0,
    WID_FULL64 = 2'd1,
    WID_32     = 2'd2,
    WID_NAT64  = 2'd3
  } widthClass_e;

  typedef enum logic [1:0] {
    TYP_CTRL   = 2'd0,
    TYP_RODATA = 2'd1,
    TYP_GUEST  = 2'd2,
    TYP_HOST   = 2'd3
  } typeClass_e;

  // How the datapath shapes data on the way in and out of a slot
  typedef enum logic [1:0] {
    SHAPE_LO16 = 2'd0,
    SHAPE_LO32 = 2'd1,
    SHAPE_ALL  = 2'd2,
    SHAPE_HI   = 2'd3
  } shape_e;

  typedef struct packed {
    logic [8:0]  index;
    typeClass_e  typ;
    widthClass_e width;
    logic        highAcc;
  } encFields_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   wrEn;
    logic   rdEn;
    logic   fail;
    shape_e shape;
  } ctrlStrobe_t;

  function automatic encFields_t splitEncoding(input logic [31:0] enc);
    encFields_t f;
    f.index   = enc[9:1];
    f.typ     = typeClass_e'(enc[11:10]);
    f.width   = widthClass_e'(enc[14:13]);
    f.highAcc = enc[0];
    return f;
  endfunction

endpackage

// File: rtl/encfield_ctrl.sv
`timescale 1ns/1ps
module encfield_ctrl
  import encfield_pkg::*;
#(
  parameter int FIELDS_PER_CLASS = 4,
  parameter int SLOTW            = 6
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [63:0]       reqEncoding,
  input  logic              mode64,
  output ctrlStrobe_t       strobe,
  output logic [SLOTW-1:0]  slotSel
);

  encFields_t fields;
  logic       resvBad;
  logic       upperBad;
  logic       accBad;
  logic       idxBad;
  logic       anyBad;
  int         slotNum;

  always_comb begin
    fields   = splitEncoding(reqEncoding[31:0]);
    // R2: reserved encoding bits
    resvBad  = (|reqEncoding[31:15]) | reqEncoding[12];
    // R3: operand bits above 31 only matter in 64-bit mode
    upperBad = mode64 & (|reqEncoding[63:32]);
    // R4: upper-half access only exists for full 64-bit fields
    accBad   = fields.highAcc & (fields.width != WID_FULL64);
    // R5: index range implemented per width/type pair
    idxBad   = (int'(fields.index) >= FIELDS_PER_CLASS);
    anyBad   = resvBad | upperBad | accBad | idxBad;
  end

  always_comb begin
    slotNum = (int'({fields.width, fields.typ}) * FIELDS_PER_CLASS) + int'(fields.index);
    slotSel = idxBad ? '0 : SLOTW'(slotNum);
  end

  always_comb begin
    strobe.wrEn = reqValid & reqWrite & ~anyBad;
    strobe.rdEn = reqValid & ~reqWrite & ~anyBad;
    strobe.fail = reqValid & anyBad;
    if (fields.highAcc) begin
      strobe.shape = SHAPE_HI;
    end else begin
      unique case (fields.width)
        WID_16:     strobe.shape = SHAPE_LO16;
        WID_32:     strobe.shape = SHAPE_LO32;
        WID_FULL64,
        WID_NAT64:  strobe.shape = mode64 ? SHAPE_ALL : SHAPE_LO32;
        default:    strobe.shape = SHAPE_LO32;
      endcase
    end
  end

endmodule

// File: rtl/encfield_datapath.sv
`timescale 1ns/1ps
module encfield_datapath
  import encfield_pkg::*;
#(
  parameter int SLOTS = 64,
  parameter int SLOTW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [SLOTW-1:0]  slotSel,
  input  logic [63:0]       reqWdata,
  output logic [63:0]       rspRdata,
  output logic              rspFail
);

  logic [SLOTS-1:0][63:0] fieldMem;
  logic [63:0]            curField;
  logic [63:0]            wrValue;
  logic [63:0]            rdShaped;

  always_comb begin
    curField = (int'(slotSel) < SLOTS) ? fieldMem[slotSel] : '0;
  end

  // Write shaping: R7, R8, R9, R10, R11
  always_comb begin
    unique case (strobe.shape)
      SHAPE_LO16: wrValue = {48'd0, reqWdata[15:0]};
      SHAPE_LO32: wrValue = {32'd0, reqWdata[31:0]};
      SHAPE_ALL:  wrValue = reqWdata;
      SHAPE_HI:   wrValue = {reqWdata[31:0], curField[31:0]};
      default:    wrValue = '0;
    endcase
  end

  // Read shaping
  always_comb begin
    unique case (strobe.shape)
      SHAPE_LO16: rdShaped = {48'd0, curField[15:0]};
      SHAPE_LO32: rdShaped = {32'd0, curField[31:0]};
      SHAPE_ALL:  rdShaped = curField;
      SHAPE_HI:   rdShaped = {32'd0, curField[63:32]};
      default:    rdShaped = '0;
    endcase
  end

  // R1 reset, R12 one-cycle response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fieldMem <= '0;
      rspRdata <= '0;
      rspFail  <= 1'b0;
    end else begin
      if (strobe.wrEn) begin
        fieldMem[slotSel] <= wrValue;
      end
      rspFail  <= strobe.fail;
      rspRdata <= strobe.rdEn ? rdShaped : '0;
    end
  end

  // R6
  fail_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fail |=> (rspFail && rspRdata == '0));

  // R6
  fail_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fail |=> $stable(fieldMem));

  // R6
  fail_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.fail |=> !rspFail);

  // R11
  hi_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && strobe.shape == SHAPE_HI) |=>
      (fieldMem[$past(slotSel)][31:0] == $past(curField[31:0])));

  // R7
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rdEn && strobe.shape == SHAPE_LO16) |=> (rspRdata[63:16] == '0));

  // R12
  no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.rdEn |=> (rspRdata == '0));

  // R13
  write_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && int'(slotSel) != 0) |=> $stable(fieldMem[0]));

endmodule

// File: rtl/encfield_access_unit.sv
`timescale 1ns/1ps
module encfield_access_unit
  import encfield_pkg::*;
#(
  parameter int FIELDS_PER_CLASS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [63:0] reqEncoding,
  input  logic [63:0] reqWdata,
  input  logic        mode64,
  output logic [63:0] rspRdata,
  output logic        rspFail
);

  localparam int CLASS_PAIRS = 16;
  localparam int SLOTS       = CLASS_PAIRS * FIELDS_PER_CLASS;
  localparam int SLOTW       = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  ctrlStrobe_t      strobe;
  logic [SLOTW-1:0] slotSel;

  encfield_ctrl #(
    .FIELDS_PER_CLASS(FIELDS_PER_CLASS),
    .SLOTW(SLOTW)
  ) ctrl_i (
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqEncoding(reqEncoding),
    .mode64(mode64),
    .strobe(strobe),
    .slotSel(slotSel)
  );

  encfield_datapath #(
    .SLOTS(SLOTS),
    .SLOTW(SLOTW)
  ) dp_i (
    .clk(clk),
    .rst_n(rst_n),
    .strobe(strobe),
    .slotSel(slotSel),
    .reqWdata(reqWdata),
    .rspRdata(rspRdata),
    .rspFail(rspFail)
  );

endmodule

// File: tb/encfield_access_unit_tb.sv
`timescale 1ns/1ps
module encfield_access_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [63:0] reqEncoding = '0;
  logic [63:0] reqWdata = '0;
  logic        mode64 = 1'b0;
  logic [63:0] rspRdata;
  logic        rspFail;

  int checks = 0;
  int misses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  encfield_access_unit #(.FIELDS_PER_CLASS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqEncoding(reqEncoding), .reqWdata(reqWdata), .mode64(mode64),
    .rspRdata(rspRdata), .rspFail(rspFail)
  );

  typedef struct packed {
    logic        wr;
    logic        m64;
    logic [63:0] enc;
    logic [63:0] wdata;
    logic [63:0] expData;
    logic        expFail;
    logic [7:0]  reqNo;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    // R7 / R12: write 16-bit then read it back in the next cycle
    '{1'b1, 1'b1, 64'h0802, 64'hAAAABBBBCCCC1234, 64'h0, 1'b0, 8'd7},
    '{1'b0, 1'b1, 64'h0802, 64'h0, 64'h1234, 1'b0, 8'd12},
    '{1'b0, 1'b0, 64'h0802, 64'h0, 64'h1234, 1'b0, 8'd7},
    // R8: 32-bit field
    '{1'b1, 1'b0, 64'h4406, 64'h1111222287654321, 64'h0, 1'b0, 8'd8},
    '{1'b0, 1'b1, 64'h4406, 64'h0, 64'h87654321, 1'b0, 8'd8},
    // R10: full 64-bit in 64-bit mode
    '{1'b1, 1'b1, 64'h2C04, 64'hDEADBEEF01234567, 64'h0, 1'b0, 8'd10},
    '{1'b0, 1'b1, 64'h2C04, 64'h0, 64'hDEADBEEF01234567, 1'b0, 8'd10},
    // R9: full read outside 64-bit mode
    '{1'b0, 1'b0, 64'h2C04, 64'h0, 64'h01234567, 1'b0, 8'd9},
    // R11: upper-half access
    '{1'b0, 1'b0, 64'h2C05, 64'h0, 64'hDEADBEEF, 1'b0, 8'd11},
    '{1'b1, 1'b1, 64'h2C05, 64'hFFFFFFFFCAFEF00D, 64'h0, 1'b0, 8'd11},
    '{1'b0, 1'b1, 64'h2C04, 64'h0, 64'hCAFEF00D01234567, 1'b0, 8'd11},
    // R9: full write outside 64-bit mode clears upper half
    '{1'b1, 1'b0, 64'h2C04, 64'h9999999955556666, 64'h0, 1'b0, 8'd9},
    '{1'b0, 1'b1, 64'h2C04, 64'h0, 64'h55556666, 1'b0, 8'd9},
    '{1'b0, 1'b1, 64'h2C05, 64'h0, 64'h0, 1'b0, 8'd9},
    // R10: natural 64-bit field
    '{1'b1, 1'b1, 64'h6800, 64'h0102030405060708, 64'h0, 1'b0, 8'd10},
    '{1'b0, 1'b1, 64'h6800, 64'h0, 64'h0102030405060708, 1'b0, 8'd10},
    '{1'b0, 1'b0, 64'h6800, 64'h0, 64'h05060708, 1'b0, 8'd9},
    // R13: neighbouring index and type are separate
    '{1'b1, 1'b1, 64'h0800, 64'h7777, 64'h0, 1'b0, 8'd13},
    '{1'b0, 1'b1, 64'h0802, 64'h0, 64'h1234, 1'b0, 8'd13},
    '{1'b0, 1'b1, 64'h0000, 64'h0, 64'h0, 1'b0, 8'd13},
    '{1'b0, 1'b1, 64'h0800, 64'h0, 64'h7777, 1'b0, 8'd13},
    // R2: reserved bits
    '{1'b1, 1'b1, 64'h8802, 64'hFFFF, 64'h0, 1'b1, 8'd2},
    '{1'b1, 1'b1, 64'h1802, 64'hFFFF, 64'h0, 1'b1, 8'd2},
    // R3: upper operand bits
    '{1'b1, 1'b1, 64'h0000000100000802, 64'hFFFF, 64'h0, 1'b1, 8'd3},
    '{1'b0, 1'b0, 64'h0000000100000802, 64'h0, 64'h1234, 1'b0, 8'd3},
    // R4: access-type bit on non-full widths
    '{1'b1, 1'b1, 64'h0803, 64'hFFFF, 64'h0, 1'b1, 8'd4},
    '{1'b0, 1'b1, 64'h4407, 64'h0, 64'h0, 1'b1, 8'd4},
    // R5: index out of range
    '{1'b1, 1'b1, 64'h0808, 64'hFFFF, 64'h0, 1'b1, 8'd5},
    '{1'b0, 1'b0, 64'h0808, 64'h0, 64'h0, 1'b1, 8'd5},
    // R6: failed read, then storage proven unchanged
    '{1'b0, 1'b1, 64'h8802, 64'h0, 64'h0, 1'b1, 8'd6},
    '{1'b0, 1'b1, 64'h0802, 64'h0, 64'h1234, 1'b0, 8'd6}
  };

  task automatic check(input string tag, input logic [63:0] gotD, input logic gotF,
                       input logic [63:0] expD, input logic expF);
    checks++;
    if (gotD !== expD || gotF !== expF) begin
      misses++;
      $display("FAIL %s: rdata=%h fail=%b expected rdata=%h fail=%b", tag, gotD, gotF, expD, expF);
    end
  endtask

  task automatic issue(input logic wr, input logic m64, input logic [63:0] enc,
                       input logic [63:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; mode64 = m64; reqEncoding = enc; reqWdata = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqEncoding = '0; reqWdata = '0;
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs low in reset
    check("R1 reset outputs", rspRdata, rspFail, 64'h0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    // R1: storage reads zero after reset
    issue(1'b0, 1'b1, 64'h6800, 64'h0);
    check("R1 read after reset", rspRdata, rspFail, 64'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].wr, VECS[i].m64, VECS[i].enc, VECS[i].wdata);
      check($sformatf("R%0d vector %0d", VECS[i].reqNo, i), rspRdata, rspFail,
            VECS[i].expData, VECS[i].expFail);
    end

    // R6 fail lasts one cycle; R12 idle cycle has zero data
    issue(1'b1, 1'b1, 64'h9000, 64'h1);
    check("R6 fail raised", rspRdata, rspFail, 64'h0, 1'b1);
    idle();
    check("R12 idle after fail", rspRdata, rspFail, 64'h0, 1'b0);

    // R1: second reset clears stored fields
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    issue(1'b0, 1'b1, 64'h6800, 64'h0);
    check("R1 field cleared by reset", rspRdata, rspFail, 64'h0, 1'b0);
    issue(1'b0, 1'b1, 64'h0802, 64'h0);
    check("R1 16-bit field cleared", rspRdata, rspFail, 64'h0, 1'b0);
    idle();
    finishRun();
  end

  initial begin
    #800000;
    misses++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

endmodule